// File: doc/BRIEF.md
# Ordered-Response Write Slave

This block is the write side of an AXI3-style slave that sits in front of a small register array. It takes address/control handshakes and write-data handshakes in whichever order the master presents them, including in the same cycle. Write beats that arrive while the address is still unknown are parked in a small beat buffer. They reach the register array only after the target word address is latched. Beats then go to consecutive words, starting at the latched address and wrapping at the top of the array. Each byte lane is gated by its strobe bit.

The write response is ordered more strictly than AXI3 requires. It is raised only when three conditions hold: the address handshake has completed, the beat flagged as last has been accepted, and every buffered beat has been committed. Only one write is in flight at a time. The address and data channels stay closed from their own completion until the response handshake. A combinational look-up port exposes any word of the array, so the stored contents can be inspected.

Top module: `wr_order_slave`

## Requirements
- R1: While reset is held and until it has been released for two clock edges, aw_ready, w_ready and b_valid are low. After that, both ready outputs are high, b_valid is low and every stored word reads zero.
- R2: b_valid never rises unless an address handshake (valid and ready high in one cycle) has completed for the current write. A burst whose data is complete but whose address has not arrived produces no response.
- R3: b_valid never rises unless the data beat with w_last high has been accepted for the current write.
- R4: Beats accepted before the address are held in a buffer of BUF_DEPTH beats. w_ready is low while that buffer is full and the address is unknown. No beat is lost, and the stalled beats are stored once the address arrives.
- R5: Beat k of a write is stored at word (aw_addr + k) modulo 2**ADDR_W. Strobe bit i enables byte i, which is data bits [8i+7:8i]. Unselected bytes keep their old value.
- R6: b_valid rises only after all buffered beats have been committed. Once high, it stays high with b_id unchanged until b_ready is sampled high.
- R7: aw_ready is low from the cycle after an address handshake until the response handshake. w_ready is low from the cycle after the last beat is accepted until the response handshake.
- R8: b_resp is always 2'b00 (OKAY) and b_id equals the aw_id captured by the address handshake.
- R9: Address-first, data-first and same-cycle orderings of the two channels store the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_aw_valid | input | 1 | Address/control valid |
| s_aw_ready | output | 1 | Address/control ready |
| s_aw_id | input | ID_W | Write transaction ID |
| s_aw_addr | input | ADDR_W | Starting word address |
| s_w_valid | input | 1 | Write beat valid |
| s_w_ready | output | 1 | Write beat ready |
| s_w_data | input | DATA_W | Write beat data |
| s_w_strb | input | DATA_W/8 | Byte-lane enables |
| s_w_last | input | 1 | Final beat of the burst |
| s_b_valid | output | 1 | Write response valid |
| s_b_ready | input | 1 | Write response ready |
| s_b_id | output | ID_W | Response ID |
| s_b_resp | output | 2 | Response code, always OKAY |
| peek_addr | input | ADDR_W | Word select for inspection |
| peek_data | output | DATA_W | Selected stored word, combinational |

## Verification
The ready outputs change on the edge that follows the handshake that closes them. A beat accepted at one edge is written into the array at the next edge, so peek_data shows it one cycle after acceptance. b_valid rises two edges after the last beat is accepted when the address is already latched, and otherwise one edge after the buffer drains. The bench model advances on the same rising edges from the driven inputs alone and is compared with every output on the falling edge, so each result is checked in the cycle it becomes due. The directed checks also hold the response low through waits of several cycles at the points where R2 and R3 forbid it.

// File: rtl/wos_pkg.sv
package wos_pkg;
  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY = 2'b00;
endpackage

// File: rtl/wos_rst_sync.sv
module wos_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n = stage2_q;
endmodule

// File: rtl/wos_beat_buf.sv
module wos_beat_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push,
  input  logic [DATA_W-1:0]   push_data,
  input  logic [DATA_W/8-1:0] push_strb,
  input  logic                pop,
  output logic [DATA_W-1:0]   head_data,
  output logic [DATA_W/8-1:0] head_strb,
  output logic                full,
  output logic                empty
);
  localparam int STRB_W = DATA_W / 8;
  localparam int PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW     = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [STRB_W-1:0] strb_mem [DEPTH];
  logic [PW-1:0]     wr_ptr_q, wr_ptr_d;
  logic [PW-1:0]     rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     count_q,  count_d;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    ptr_next = (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push) wr_ptr_d = ptr_next(wr_ptr_q);
    if (pop)  rd_ptr_d = ptr_next(rd_ptr_q);
    count_d = count_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      data_mem[wr_ptr_q] <= push_data;
      strb_mem[wr_ptr_q] <= push_strb;
    end
  end

  assign head_data = data_mem[rd_ptr_q];
  assign head_strb = strb_mem[rd_ptr_q];
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
endmodule

// File: rtl/wos_word_store.sv
module wos_word_store #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [DATA_W/8-1:0] wr_strb,
  input  logic [ADDR_W-1:0]   rd_idx,
  output logic [DATA_W-1:0]   rd_data
);
  localparam int WORDS  = 1 << ADDR_W;
  localparam int STRB_W = DATA_W / 8;

  logic [DATA_W-1:0] words_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_idx == ADDR_W'(w));
    for (genvar b = 0; b < STRB_W; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          words_q[w][b*8 +: 8] <= '0;
        end else if (sel && wr_strb[b]) begin
          words_q[w][b*8 +: 8] <= wr_data[b*8 +: 8];
        end
      end
    end
  end

  assign rd_data = words_q[rd_idx];
endmodule

// File: rtl/wos_wr_ctrl.sv
module wos_wr_ctrl #(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic              w_valid,
  input  logic              w_last,
  input  logic              b_ready,
  input  logic              buf_full,
  input  logic              buf_empty,
  output logic              aw_ready,
  output logic              w_ready,
  output logic              push,
  output logic              pop,
  output logic [ADDR_W-1:0] wr_idx,
  output logic              b_valid,
  output logic [ID_W-1:0]   b_id,
  output logic              addr_known
);
  logic              aw_done_q, aw_done_d;
  logic              w_done_q,  w_done_d;
  logic              b_valid_q, b_valid_d;
  logic [ADDR_W-1:0] base_q,    base_d;
  logic [ADDR_W-1:0] beat_q,    beat_d;
  logic [ID_W-1:0]   id_q,      id_d;
  logic              aw_hs, b_hs;

  // Handshake qualifiers; rst_n is the synchronised reset and doubles as "live".
  always_comb begin
    aw_ready = rst_n && !aw_done_q;
    w_ready  = rst_n && !w_done_q && (!buf_full || aw_done_q);
    aw_hs    = aw_valid && aw_ready;
    push     = w_valid && w_ready;
    pop      = aw_done_q && !buf_empty;
    b_hs     = b_valid_q && b_ready;
  end

  always_comb begin
    aw_done_d = aw_done_q;
    w_done_d  = w_done_q;
    b_valid_d = b_valid_q;
    base_d    = base_q;
    beat_d    = beat_q;
    id_d      = id_q;
    if (b_hs) begin
      aw_done_d = 1'b0;
      w_done_d  = 1'b0;
      b_valid_d = 1'b0;
      beat_d    = '0;
    end else begin
      if (aw_hs) begin
        aw_done_d = 1'b1;
        base_d    = aw_addr;
        id_d      = aw_id;
      end
      if (push && w_last) w_done_d = 1'b1;
      if (pop)            beat_d   = beat_q + ADDR_W'(1);
      if (aw_done_q && w_done_q && buf_empty && !b_valid_q) b_valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_done_q <= 1'b0;
      w_done_q  <= 1'b0;
      b_valid_q <= 1'b0;
      base_q    <= '0;
      beat_q    <= '0;
      id_q      <= '0;
    end else begin
      aw_done_q <= aw_done_d;
      w_done_q  <= w_done_d;
      b_valid_q <= b_valid_d;
      base_q    <= base_d;
      beat_q    <= beat_d;
      id_q      <= id_d;
    end
  end

  assign wr_idx     = base_q + beat_q;
  assign b_valid    = b_valid_q;
  assign b_id       = id_q;
  assign addr_known = aw_done_q;
endmodule

// File: rtl/wr_order_slave.sv
module wr_order_slave #(
  parameter int DATA_W    = 32,
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 4,
  parameter int BUF_DEPTH = 4
) (
  input  logic                aclk,
  input  logic                aresetn,
  input  logic                s_aw_valid,
  output logic                s_aw_ready,
  input  logic [ID_W-1:0]     s_aw_id,
  input  logic [ADDR_W-1:0]   s_aw_addr,
  input  logic                s_w_valid,
  output logic                s_w_ready,
  input  logic [DATA_W-1:0]   s_w_data,
  input  logic [DATA_W/8-1:0] s_w_strb,
  input  logic                s_w_last,
  output logic                s_b_valid,
  input  logic                s_b_ready,
  output logic [ID_W-1:0]     s_b_id,
  output logic [1:0]          s_b_resp,
  input  logic [ADDR_W-1:0]   peek_addr,
  output logic [DATA_W-1:0]   peek_data
);
  localparam int STRB_W = DATA_W / 8;

  logic              rst_n_i;
  logic              push, pop, buf_full, buf_empty, addr_known;
  logic [ADDR_W-1:0] wr_idx;
  logic [DATA_W-1:0] head_data;
  logic [STRB_W-1:0] head_strb;

  wos_rst_sync u_rst (
    .clk    (aclk),
    .arst_n (aresetn),
    .rst_n  (rst_n_i)
  );

  wos_wr_ctrl #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (aclk),
    .rst_n      (rst_n_i),
    .aw_valid   (s_aw_valid),
    .aw_id      (s_aw_id),
    .aw_addr    (s_aw_addr),
    .w_valid    (s_w_valid),
    .w_last     (s_w_last),
    .b_ready    (s_b_ready),
    .buf_full   (buf_full),
    .buf_empty  (buf_empty),
    .aw_ready   (s_aw_ready),
    .w_ready    (s_w_ready),
    .push       (push),
    .pop        (pop),
    .wr_idx     (wr_idx),
    .b_valid    (s_b_valid),
    .b_id       (s_b_id),
    .addr_known (addr_known)
  );

  wos_beat_buf #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk       (aclk),
    .rst_n     (rst_n_i),
    .push      (push),
    .push_data (s_w_data),
    .push_strb (s_w_strb),
    .pop       (pop),
    .head_data (head_data),
    .head_strb (head_strb),
    .full      (buf_full),
    .empty     (buf_empty)
  );

  wos_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (aclk),
    .rst_n   (rst_n_i),
    .wr_en   (pop),
    .wr_idx  (wr_idx),
    .wr_data (head_data),
    .wr_strb (head_strb),
    .rd_idx  (peek_addr),
    .rd_data (peek_data)
  );

  assign s_b_resp = wos_pkg::RESP_OKAY;
endmodule

// File: rtl/wos_checker.sv
module wos_checker #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            arst_n,
  input logic            aw_valid,
  input logic            aw_ready,
  input logic            w_valid,
  input logic            w_ready,
  input logic            w_last,
  input logic            b_valid,
  input logic            b_ready,
  input logic [ID_W-1:0] b_id,
  input logic [1:0]      b_resp,
  input logic            buf_full,
  input logic            addr_known
);
  logic aw_seen_q, last_seen_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      aw_seen_q   <= 1'b0;
      last_seen_q <= 1'b0;
    end else if (b_valid && b_ready) begin
      aw_seen_q   <= 1'b0;
      last_seen_q <= 1'b0;
    end else begin
      if (aw_valid && aw_ready)          aw_seen_q   <= 1'b1;
      if (w_valid && w_ready && w_last)  last_seen_q <= 1'b1;
    end
  end

  p_bvalid_after_aw_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(b_valid) |-> aw_seen_q);

  p_bvalid_after_last_r3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(b_valid) |-> last_seen_q);

  p_stall_when_full_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (buf_full && !addr_known) |-> !w_ready);

  p_bvalid_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (b_valid && !b_ready) |=> (b_valid && $stable(b_id)));

  p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!arst_n)
    b_valid |-> (!aw_ready && !w_ready));

  p_resp_okay_r8: assert property (@(posedge clk) disable iff (!arst_n)
    b_valid |-> (b_resp == 2'b00));
endmodule

bind wr_order_slave wos_checker #(.ID_W(ID_W)) u_chk (
  .clk        (aclk),
  .arst_n     (aresetn),
  .aw_valid   (s_aw_valid),
  .aw_ready   (s_aw_ready),
  .w_valid    (s_w_valid),
  .w_ready    (s_w_ready),
  .w_last     (s_w_last),
  .b_valid    (s_b_valid),
  .b_ready    (s_b_ready),
  .b_id       (s_b_id),
  .b_resp     (s_b_resp),
  .buf_full   (buf_full),
  .addr_known (addr_known)
);

// File: tb/test_wr_order_slave.sv
`timescale 1ns/1ps
module test_wr_order_slave;
  localparam int DW = 32, IW = 4, AW = 4, BD = 4, WORDS = 16;

  logic          clk = 1'b0;
  logic          aresetn;
  logic          aw_valid, aw_ready, w_valid, w_ready, w_last;
  logic          b_valid, b_ready;
  logic [IW-1:0] aw_id, b_id;
  logic [AW-1:0] aw_addr, peek_addr;
  logic [DW-1:0] w_data, peek_data;
  logic [3:0]    w_strb;
  logic [1:0]    b_resp;

  int n_checks = 0, n_err = 0;

  always #4 clk = ~clk;

  wr_order_slave #(.DATA_W(DW), .ID_W(IW), .ADDR_W(AW), .BUF_DEPTH(BD)) i_wr_order_slave (
    .aclk(clk), .aresetn(aresetn),
    .s_aw_valid(aw_valid), .s_aw_ready(aw_ready), .s_aw_id(aw_id), .s_aw_addr(aw_addr),
    .s_w_valid(w_valid), .s_w_ready(w_ready), .s_w_data(w_data), .s_w_strb(w_strb), .s_w_last(w_last),
    .s_b_valid(b_valid), .s_b_ready(b_ready), .s_b_id(b_id), .s_b_resp(b_resp),
    .peek_addr(peek_addr), .peek_data(peek_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [35:0] m_q[$];
  logic [31:0] m_mem [WORDS];
  bit          m_rs1, m_rs2, m_aw, m_wd, m_bv;
  int          m_base, m_idx;
  logic [IW-1:0] m_id;

  function automatic bit m_awrdy();
    return m_rs2 && !m_aw;
  endfunction
  function automatic bit m_wrdy();
    return m_rs2 && !m_wd && (m_q.size() < BD || m_aw);
  endfunction

  always @(posedge clk or negedge aresetn) begin
    if (!aresetn) begin
      m_rs1 = 0; m_rs2 = 0; m_aw = 0; m_wd = 0; m_bv = 0;
      m_base = 0; m_idx = 0; m_id = '0; m_q.delete();
      for (int i = 0; i < WORDS; i++) m_mem[i] = '0;
    end else begin
      if (m_rs2) begin
        bit pre_empty, push, pop, bhs, awhs;
        pre_empty = (m_q.size() == 0);
        push = w_valid && m_wrdy();
        pop  = m_aw && !pre_empty;
        bhs  = m_bv && b_ready;
        awhs = aw_valid && m_awrdy();
        if (pop) begin
          logic [35:0] e;
          int wi;
          e  = m_q.pop_front();
          wi = (m_base + m_idx) % WORDS;
          for (int b = 0; b < 4; b++)
            if (e[32+b]) m_mem[wi][b*8 +: 8] = e[b*8 +: 8];
          m_idx++;
        end
        if (push) m_q.push_back({w_strb, w_data});
        if (bhs) begin
          m_bv = 0; m_aw = 0; m_wd = 0; m_idx = 0;
        end else begin
          if (m_aw && m_wd && pre_empty && !m_bv) m_bv = 1;
          if (awhs) begin m_aw = 1; m_base = int'(aw_addr); m_id = aw_id; end
          if (push && w_last) m_wd = 1;
        end
      end
      m_rs2 = m_rs1;
      m_rs1 = 1;
    end
  end

  // ---------------- per-cycle comparison ----------------
  bit            peek_en = 0;
  logic [AW-1:0] peek_sel = '0;
  int            sweep = 0;

  always @(negedge clk) begin
    check("R7 aw_ready", {31'b0, aw_ready}, {31'b0, m_awrdy()});
    check("R4 w_ready",  {31'b0, w_ready},  {31'b0, m_wrdy()});
    check("R6 b_valid",  {31'b0, b_valid},  {31'b0, m_bv});
    if (m_bv) begin
      check("R8 b_id",   {28'b0, b_id},   {28'b0, m_id});
      check("R8 b_resp", {30'b0, b_resp}, 32'h0);
    end
    check("R5 peek_data", peek_data, m_mem[peek_addr]);
    sweep++;
    peek_addr = peek_en ? peek_sel : AW'(sweep);
  end

  // ---------------- stimulus tasks ----------------
  task automatic do_aw(input logic [IW-1:0] id, input logic [AW-1:0] a);
    bit done = 0;
    @(negedge clk);
    aw_valid = 1; aw_id = id; aw_addr = a;
    while (!done) begin #1; done = aw_ready; @(negedge clk); end
    aw_valid = 0;
  endtask

  task automatic send_w(input logic [31:0] d, input logic [3:0] s, input bit last);
    bit done = 0;
    @(negedge clk);
    w_valid = 1; w_data = d; w_strb = s; w_last = last;
    while (!done) begin #1; done = w_ready; @(negedge clk); end
    w_valid = 0; w_last = 0;
  endtask

  task automatic wait_b(input int dly);
    do begin @(negedge clk); #1; end while (!b_valid);
    repeat (dly) @(negedge clk);
    b_ready = 1;
    @(negedge clk);
    b_ready = 0;
  endtask

  task automatic peek(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    peek_sel = a; peek_en = 1;
    @(negedge clk); #1;
    check(tag, peek_data, exp);
    peek_en = 0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    aresetn = 0; aw_valid = 0; aw_id = '0; aw_addr = '0;
    w_valid = 0; w_data = '0; w_strb = '0; w_last = 0; b_ready = 0; peek_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 aw_ready in reset", {31'b0, aw_ready}, 32'h0);
    check("R1 w_ready in reset",  {31'b0, w_ready},  32'h0);
    aresetn = 1;
    repeat (4) @(negedge clk);
    #1;
    check("R1 aw_ready after reset", {31'b0, aw_ready}, 32'h1);
    check("R1 w_ready after reset",  {31'b0, w_ready},  32'h1);
    check("R1 b_valid after reset",  {31'b0, b_valid},  32'h0);
    peek(4'd9, 32'h0, "R1 word zero");

    // R3: address first, last beat withheld
    do_aw(4'd3, 4'd2);
    for (int i = 0; i < 3; i++) send_w(32'h1000_0000 + i, 4'hF, 0);
    repeat (6) @(negedge clk);
    #1 check("R3 no response before last", {31'b0, b_valid}, 32'h0);
    send_w(32'h1000_0003, 4'hF, 1);
    wait_b(3);
    peek(4'd3, 32'h1000_0001, "R5 consecutive word");

    // R2: data first, address withheld
    for (int i = 0; i < 3; i++) send_w(32'h3000_0000 + i, 4'hF, i == 2);
    repeat (6) @(negedge clk);
    #1 check("R2 no response before address", {31'b0, b_valid}, 32'h0);
    check("R7 w_ready closed after last", {31'b0, w_ready}, 32'h0);
    do_aw(4'd5, 4'd10);
    wait_b(0);
    peek(4'd11, 32'h3000_0001, "R9 data-first stored");

    // R4: data first, buffer overflows, stall until address
    fork
      for (int i = 0; i < 6; i++) send_w(32'h4000_0000 + i, 4'hF, i == 5);
      begin
        repeat (12) @(negedge clk);
        #1 check("R4 stall when full", {31'b0, w_ready}, 32'h0);
        do_aw(4'd6, 4'd4);
      end
    join
    wait_b(1);
    peek(4'd9, 32'h4000_0005, "R4 stalled beat stored");

    // R5: byte strobes
    do_aw(4'd7, 4'd8);
    send_w(32'hAABB_CCDD, 4'b0101, 1);
    wait_b(0);
    peek(4'd8, 32'h40BB_00DD, "R5 strobe merge");

    // R5: wrap at top of array
    do_aw(4'd9, 4'd14);
    for (int i = 0; i < 4; i++) send_w(32'h2000_0000 + i, 4'hF, i == 3);
    wait_b(2);
    peek(4'd0, 32'h2000_0002, "R5 wrap");

    // R9: same-cycle address and data
    fork
      do_aw(4'd12, 4'd6);
      for (int i = 0; i < 2; i++) send_w(32'h5000_0000 + i, 4'hF, i == 1);
    join
    wait_b(0);
    peek(4'd7, 32'h5000_0001, "R9 same-cycle stored");
    peek(4'd6, 32'h5000_0000, "R8 R9 first word of same-cycle burst");

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule